// File: doc/BRIEF.md
# Dual Interval Timer with Identification Bytes

This block holds two independent down-counting interval timers behind one register window of 1024 words (4 KB of byte space) and drives a single interrupt line that is the OR of both timers' masked interrupts. A bus master reaches it through a plain read/write strobe interface with a word address. The first eight words belong to timer 0 and the next eight to timer 1. Each timer sees only its own relative word index. The top eight words of the window return fixed identification bytes. Every other location reads as zero, and writes to those locations are dropped.

Each timer has its own tick-enable input, so the two can count at unrelated rates taken from one clock. Both rates are the same by default, and the integrator may drive either enable from any source. The control register of a timer selects the mode (periodic, one-shot or free-running), a prescaler of 1, 16 or 256 ticks, a 16- or 32-bit wrap for free-running mode, an interrupt mask and a run bit. Read data is registered and appears in the cycle after the read strobe.

Per-timer word map, as a relative index: 0 load (writing it also sets the count), 1 current count (read-only), 2 control, 3 interrupt clear (write), 4 raw interrupt, 5 masked interrupt, 6 reload-only load. Control bits: [0] one-shot, [1] 32-bit wrap, [3:2] prescale (1=/16, 2=/256, else /1), [5] interrupt enable, [6] periodic, [7] run.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, rdata and irq are 0, each timer's control reads 0x20 (interrupt enabled, stopped), and its load and count read 0.
- R2: Word addresses 0x00–0x07 (byte 0x00–0x1F) reach timer 0 and 0x08–0x0F (byte 0x20–0x3F) reach timer 1 at relative index waddr-8. A load written to one timer does not change the other.
- R3: Word addresses 0x3F8–0x3FF (byte 0xFE0–0xFFC) read, in address order, 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R4: Reads of any word outside the two timer ranges and the identification range, including byte offsets 0xF00 and 0xF04, return 0. Writes outside the two timer ranges, including the identification words, change no readable value.
- R5: rdata takes the addressed value in the cycle after rd_en is high and holds it until the next read.
- R6: In periodic mode with load N, the raw interrupt sets on the N-th counted tick and the count reloads to N.
- R7: In one-shot mode, expiry sets the raw interrupt, leaves the count at 0 and clears the run bit, so later ticks have no effect.
- R8: In free-running mode, expiry reloads the count to 0xFFFF with the 32-bit bit clear and to 0xFFFFFFFF with it set.
- R9: The masked interrupt word reads raw AND enable. irq is the OR of both timers' masked interrupts. A write to relative index 3 clears the raw interrupt.
- R10: With prescale /16, the count steps only on every 16th tick after the last control write.
- R11: A timer counts only on cycles where its own tick enable is high. Ticks for the other timer leave it unchanged.
- R12: A write to relative index 6 changes the reload value but not the current count, and writes to the count word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 2 | Per-timer count enable, bit i for timer i |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| waddr | input | 10 | Word address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
A decode error shows up at the first read of the affected word. It appears as a wrong or non-zero rdata one cycle after the strobe, or as a load value that has leaked into the other timer. A counter or prescaler in the wrong state shows within one timer period: irq rises a tick early or late, or the count read back after expiry is not the expected reload value. A timer that takes the wrong tick enable advances while only the other timer is being ticked, and the next count read exposes it.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int DATA_W = 32;
  localparam int PRE_W  = 8;
  localparam int REL_W  = 3;

  localparam int C_ONESHOT = 0;
  localparam int C_WIDE    = 1;
  localparam int C_PRE_LO  = 2;
  localparam int C_IE      = 5;
  localparam int C_PERIOD  = 6;
  localparam int C_RUN     = 7;

  localparam logic [7:0] CTRL_RST = 8'h20;

  typedef enum logic [REL_W-1:0] {
    W_LOAD  = 3'd0,
    W_COUNT = 3'd1,
    W_CTRL  = 3'd2,
    W_CLR   = 3'd3,
    W_RAW   = 3'd4,
    W_MASK  = 3'd5,
    W_BGLD  = 3'd6,
    W_NONE  = 3'd7
  } rel_word_e;

  function automatic logic [7:0] ident_byte(input logic [REL_W-1:0] idx);
    case (idx)
      3'd0: ident_byte = 8'h04;
      3'd1: ident_byte = 8'h18;
      3'd2: ident_byte = 8'h14;
      3'd3: ident_byte = 8'h00;
      3'd4: ident_byte = 8'h0D;
      3'd5: ident_byte = 8'hF0;
      3'd6: ident_byte = 8'h05;
      default: ident_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dtt_decode.sv
module dtt_decode
  import dtt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int N_TMR  = 2
) (
  input  logic [ADDR_W-1:0] waddr,
  output logic [N_TMR-1:0]  tmr_sel,
  output logic              id_hit,
  output logic [REL_W-1:0]  rel
);
  localparam int BLK_W = ADDR_W - REL_W;

  logic [BLK_W-1:0] blk;

  assign blk = waddr[ADDR_W-1:REL_W];
  assign rel = waddr[REL_W-1:0];
  assign id_hit = (blk == {BLK_W{1'b1}});

  for (genvar i = 0; i < N_TMR; i++) begin : g_sel
    assign tmr_sel[i] = (blk == BLK_W'(i));
  end
endmodule

// File: rtl/dtt_core.sv
module dtt_core
  import dtt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr,
  input  logic [REL_W-1:0]  rel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic              raw_int,
  output logic              msk_int
);
  localparam logic [CNT_W-1:0] MAX_WIDE   = '1;
  localparam logic [CNT_W-1:0] MAX_NARROW = CNT_W'(17'h0FFFF);

  logic [7:0]       ctrl_q, ctrl_n;
  logic [CNT_W-1:0] load_q, load_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [PRE_W-1:0] pre_q, pre_n;
  logic             raw_q, raw_n;

  logic [PRE_W-1:0] pmask;
  logic             run, step, expire;
  logic [CNT_W-1:0] reload;

  always_comb begin
    case (ctrl_q[C_PRE_LO+1:C_PRE_LO])
      2'd1:    pmask = PRE_W'(8'h0F);
      2'd2:    pmask = PRE_W'(8'hFF);
      default: pmask = '0;
    endcase
    run    = ctrl_q[C_RUN];
    step   = run & tick & ((pre_q & pmask) == pmask);
    expire = step & (cnt_q <= CNT_W'(1));
    if (ctrl_q[C_PERIOD] | ctrl_q[C_ONESHOT]) reload = load_q;
    else if (ctrl_q[C_WIDE])                 reload = MAX_WIDE;
    else                                     reload = MAX_NARROW;
  end

  always_comb begin
    ctrl_n = ctrl_q;
    load_n = load_q;
    cnt_n  = cnt_q;
    pre_n  = pre_q;
    raw_n  = raw_q;
    if (run & tick) pre_n = pre_q + 1'b1;
    if (step) begin
      if (!expire) begin
        cnt_n = cnt_q - 1'b1;
      end else begin
        raw_n = 1'b1;
        if (ctrl_q[C_ONESHOT]) begin
          cnt_n         = '0;
          ctrl_n[C_RUN] = 1'b0;
        end else begin
          cnt_n = reload;
        end
      end
    end
    if (wr) begin
      case (rel_word_e'(rel))
        W_LOAD: begin
          load_n = wdata[CNT_W-1:0];
          cnt_n  = wdata[CNT_W-1:0];
        end
        W_CTRL: begin
          ctrl_n = wdata[7:0];
          pre_n  = '0;
        end
        W_CLR:   if (!expire) raw_n = 1'b0;
        W_BGLD:  load_n = wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      load_q <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      raw_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      load_q <= load_n;
      cnt_q  <= cnt_n;
      pre_q  <= pre_n;
      raw_q  <= raw_n;
    end
  end

  assign raw_int = raw_q;
  assign msk_int = raw_q & ctrl_q[C_IE];

  always_comb begin
    case (rel_word_e'(rel))
      W_LOAD, W_BGLD: rd_val = DATA_W'(load_q);
      W_COUNT:        rd_val = DATA_W'(cnt_q);
      W_CTRL:         rd_val = DATA_W'(ctrl_q);
      W_RAW:          rd_val = DATA_W'(raw_q);
      W_MASK:         rd_val = DATA_W'(msk_int);
      default:        rd_val = '0;
    endcase
  end
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TMR-1:0]  tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [N_TMR-1:0]  tmr_sel;
  logic              id_hit;
  logic [REL_W-1:0]  rel;
  logic [DATA_W-1:0] core_rd [N_TMR];
  logic [N_TMR-1:0]  raw_int;
  logic [N_TMR-1:0]  msk_int;

  dtt_decode #(.ADDR_W(ADDR_W), .N_TMR(N_TMR)) u_dec (
    .waddr   (waddr),
    .tmr_sel (tmr_sel),
    .id_hit  (id_hit),
    .rel     (rel)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    dtt_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .tick    (tick_en[i]),
      .wr      (wr_en & tmr_sel[i]),
      .rel     (rel),
      .wdata   (wdata),
      .rd_val  (core_rd[i]),
      .raw_int (raw_int[i]),
      .msk_int (msk_int[i])
    );
  end

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q, rdata_n;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (tmr_sel[i]) rd_mux = core_rd[i];
    end
    if (id_hit) rd_mux = DATA_W'(ident_byte(rel));
  end

  always_comb begin
    rdata_n = rdata_q;
    if (rd_en) rdata_n = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else            rdata_q <= rdata_n;
  end

  assign rdata = rdata_q;
  assign irq   = |msk_int;
endmodule

// File: rtl/dtt_chk.sv
module dtt_chk #(
  parameter int ADDR_W = 10,
  parameter int N_TMR  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] waddr,
  input logic [31:0]       rdata,
  input logic              irq,
  input logic [N_TMR-1:0]  raw_int
);
  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));

  // R4
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && waddr >= ADDR_W'(16) && waddr < ADDR_W'(1016)) |=> (rdata == 32'h0));

  // R3
  ident_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && waddr == ADDR_W'(1016)) |=> (rdata == 32'h04));

  // R3
  ident_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && waddr == ADDR_W'(1023)) |=> (rdata == 32'hB1));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_int != '0));
endmodule

bind dual_tick_timer dtt_chk #(.ADDR_W(ADDR_W), .N_TMR(N_TMR)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en),
  .waddr   (waddr),
  .rdata   (rdata),
  .irq     (irq),
  .raw_int (raw_int)
);

// File: tb/tb_dual_tick_timer.sv
`timescale 1ns/1ps
module tb_dual_tick_timer;
  logic        clk;
  logic        rst_n;
  logic [1:0]  tick_en;
  logic        wr_en, rd_en;
  logic [9:0]  waddr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int vec_cnt;
  int err_cnt;
  bit done;

  dual_tick_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .waddr(waddr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] boff, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; waddr = boff[11:2]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] boff, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; waddr = boff[11:2];
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] boff, input logic [31:0] exp);
    logic [31:0] d;
    rd(boff, d);
    chk(req, d, exp);
  endtask

  task automatic ticks(input int which, input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en[which] = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk);
      tick_en[which] = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 ctrl0", 12'h008, 32'h20);
    rd_chk("R1 ctrl1", 12'h028, 32'h20);
    rd_chk("R1 count0", 12'h004, 32'h0);
    rd_chk("R1 load1", 12'h020, 32'h0);
  endtask

  task automatic t_decode();
    wr(12'h000, 32'h11);
    wr(12'h020, 32'h22);
    rd_chk("R2 load0", 12'h000, 32'h11);
    rd_chk("R2 load1", 12'h020, 32'h22);
    rd_chk("R2 bgload0", 12'h018, 32'h11);
    rd_chk("R2 bgload1", 12'h038, 32'h22);
  endtask

  task automatic t_ident();
    logic [7:0] exp_id [8];
    exp_id = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) rd_chk("R3 ident", 12'hFE0 + 12'(i * 4), {24'b0, exp_id[i]});
  endtask

  task automatic t_unmapped();
    wr(12'h040, 32'hAB);
    wr(12'hF00, 32'hAB);
    wr(12'hFE0, 32'hAB);
    rd_chk("R4 load0 kept", 12'h000, 32'h11);
    rd_chk("R4 load1 kept", 12'h020, 32'h22);
    rd_chk("R4 ident kept", 12'hFE0, 32'h04);
    rd_chk("R4 test ctrl", 12'hF00, 32'h0);
    rd_chk("R4 test out", 12'hF04, 32'h0);
    rd_chk("R4 hole", 12'h040, 32'h0);
    rd_chk("R4 mid", 12'h800, 32'h0);
  endtask

  task automatic t_hold();
    rd_chk("R5 read", 12'hFE4, 32'h18);
    wr(12'h040, 32'h0);
    repeat (3) @(negedge clk);
    chk("R5 hold", rdata, 32'h18);
  endtask

  task automatic t_periodic();
    wr(12'h000, 32'd5);
    wr(12'h008, 32'hE0);
    ticks(0, 4);
    chk("R6 no irq yet", {31'b0, irq}, 32'h0);
    rd_chk("R6 count", 12'h004, 32'd1);
    ticks(0, 1);
    chk("R6 irq", {31'b0, irq}, 32'h1);
    rd_chk("R6 reload", 12'h004, 32'd5);
    rd_chk("R9 raw", 12'h010, 32'h1);
    rd_chk("R9 masked", 12'h014, 32'h1);
    wr(12'h00C, 32'h0);
    chk("R9 clear irq", {31'b0, irq}, 32'h0);
    rd_chk("R9 raw cleared", 12'h010, 32'h0);
    ticks(0, 5);
    wr(12'h008, 32'hC0);
    rd_chk("R9 raw unmasked", 12'h010, 32'h1);
    rd_chk("R9 masked off", 12'h014, 32'h0);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h20);
  endtask

  task automatic t_indep();
    wr(12'h000, 32'd10);
    wr(12'h008, 32'hE0);
    wr(12'h020, 32'd3);
    wr(12'h028, 32'hE0);
    ticks(0, 3);
    rd_chk("R11 count0", 12'h004, 32'd7);
    rd_chk("R11 count1 idle", 12'h024, 32'd3);
    ticks(1, 3);
    chk("R11 irq from t1", {31'b0, irq}, 32'h1);
    rd_chk("R11 raw0", 12'h010, 32'h0);
    rd_chk("R11 raw1", 12'h030, 32'h1);
    rd_chk("R11 count0 idle", 12'h004, 32'd7);
    wr(12'h02C, 32'h0);
    chk("R9 irq after clear1", {31'b0, irq}, 32'h0);
    wr(12'h008, 32'h20);
    wr(12'h028, 32'h20);
  endtask

  task automatic t_oneshot();
    wr(12'h020, 32'd3);
    wr(12'h028, 32'hA1);
    ticks(1, 3);
    chk("R7 irq", {31'b0, irq}, 32'h1);
    rd_chk("R7 count zero", 12'h024, 32'h0);
    rd_chk("R7 run cleared", 12'h028, 32'h21);
    ticks(1, 2);
    rd_chk("R7 stays", 12'h024, 32'h0);
    wr(12'h02C, 32'h0);
  endtask

  task automatic t_free();
    wr(12'h000, 32'd2);
    wr(12'h008, 32'h80);
    ticks(0, 2);
    rd_chk("R8 narrow wrap", 12'h004, 32'h0000FFFF);
    rd_chk("R8 raw", 12'h010, 32'h1);
    chk("R9 irq off", {31'b0, irq}, 32'h0);
    wr(12'h00C, 32'h0);
    wr(12'h000, 32'd1);
    wr(12'h008, 32'h82);
    ticks(0, 1);
    rd_chk("R8 wide wrap", 12'h004, 32'hFFFFFFFF);
    wr(12'h008, 32'h00);
    wr(12'h00C, 32'h0);
  endtask

  task automatic t_prescale();
    wr(12'h000, 32'd2);
    wr(12'h008, 32'hE4);
    ticks(0, 15);
    rd_chk("R10 before 16", 12'h004, 32'd2);
    ticks(0, 1);
    rd_chk("R10 at 16", 12'h004, 32'd1);
    ticks(0, 16);
    chk("R10 irq", {31'b0, irq}, 32'h1);
    rd_chk("R10 reload", 12'h004, 32'd2);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h20);
  endtask

  task automatic t_bgload();
    wr(12'h020, 32'd8);
    wr(12'h028, 32'hC0);
    ticks(1, 2);
    wr(12'h038, 32'd3);
    rd_chk("R12 count kept", 12'h024, 32'd6);
    rd_chk("R12 load new", 12'h020, 32'd3);
    wr(12'h024, 32'h55);
    rd_chk("R12 count ro", 12'h024, 32'd6);
    ticks(1, 6);
    rd_chk("R12 reload bg", 12'h024, 32'd3);
    rd_chk("R12 raw", 12'h030, 32'h1);
    wr(12'h028, 32'h20);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = '0; wr_en = 1'b0; rd_en = 1'b0; waddr = '0; wdata = '0;
    vec_cnt = 0; err_cnt = 0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_decode();
    t_ident();
    t_unmapped();
    t_hold();
    t_periodic();
    t_indep();
    t_oneshot();
    t_free();
    t_prescale();
    t_bgload();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      err_cnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end
endmodule